// File: doc/BRIEF.md
# Six-bit GPIO port with open-drain control

This block is a six-pin general-purpose I/O port for a microcontroller. Software reaches it over a small byte-wide register bus that holds four registers: pin direction, output data, a read-only pin view and open-drain selection. The block turns those registers into a per-pin output enable and output value for the pad ring. It brings the pad inputs back through a synchronizer so that software can read them.

Each pin works in one of two output styles. In push-pull style the pad drives both levels. In open-drain style the high-side driver is turned off, so the pin can only be pulled low or released. A serial unit can take over any pin through a per-pin override, which wins over the register settings.

The block has two reset classes. Power-on reset and hardware standby clear the register contents. Manual reset and software standby keep them. Manual reset only clears the input synchronizer, and software standby blocks bus writes.

Top module: `gpio6_port`

## Requirements
- R1: While `por_n` is low or `hw_stby` is high, the direction, data and open-drain registers are zero and read back as zero. While `hw_stby` is high, every `pad_oe` and `pad_out` bit is 0, whatever the override inputs are.
- R2: Register bits 7 and 6 do not exist. Writes to them are dropped, and on every read `rdata[7:6]` is 0.
- R3: A low `mrst_n`, or bus writes made while `sw_stby` is high, leave the direction, data and open-drain registers unchanged.
- R4: The pin-view register at offset 2 is read-only. A write to offset 2 changes no register.
- R5: A read of offset 2 returns, for each bit, the data register bit when the direction bit is 1, and the synchronized pin otherwise. A change on `pin_in` shows in that read after two rising clock edges. A low `mrst_n` or `por_n` clears the synchronizer.
- R6: For a pin whose open-drain bit is 0 and whose override is off, `pad_oe` equals the direction bit and `pad_out` equals the data bit.
- R7: For a pin whose open-drain bit is 1 and whose override is off, `pad_oe` is high only when the direction bit is 1 and the data bit is 0, and `pad_out` is 0.
- R8: While `ovr_en[i]` is high and `hw_stby` is low, `pad_oe[i]` follows `ovr_oe[i]` and `pad_out[i]` follows `ovr_out[i]`.
- R9: The register map is: offset 0 direction, 1 data, 2 pin view, 3 open-drain. Any address from 4 upward reads 0 and ignores writes. A read returns its data combinationally in the same cycle as `rd_en`. When `rd_en` is low, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_stby | input | 1 | Hardware standby: clears the registers and releases the pads |
| mrst_n | input | 1 | Manual reset, active low; clears only the input synchronizer |
| sw_stby | input | 1 | Software standby: holds the registers and blocks writes |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 8 | Bus byte address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, valid in the same cycle as `rd_en` |
| pin_in | input | 6 | Pad input levels, asynchronous to `clk` |
| ovr_en | input | 6 | Per-pin serial-unit override enable |
| ovr_oe | input | 6 | Override output enable |
| ovr_out | input | 6 | Override output value |
| pad_oe | output | 6 | Pad output enable per pin |
| pad_out | output | 6 | Pad output value per pin |

## Verification
A wrong direction, data or open-drain bit shows at the pad outputs in the same cycle. It is also visible at `rdata` as soon as its offset is read. A synchronizer stage that is stuck, missing or not cleared changes the pin-view readback two edges after the pin moves. Because of this, the bench keeps reads going on rotating offsets during idle time and compares every output against the model on every cycle. A write that slips through during software standby, or a write to the pin-view offset that takes effect, shows up on the following cycle as a changed pad enable or readback.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
   typedef enum logic [1:0] {
      REG_DIR  = 2'd0,
      REG_DATA = 2'd1,
      REG_PIN  = 2'd2,
      REG_ODC  = 2'd3
   } gp_reg_e;
   localparam int unsigned GP_NUM_REGS = 4;
   localparam int unsigned GP_SEL_W    = 2;
endpackage

// File: rtl/gpio6_regs.sv
module gpio6_regs
   import gpio6_pkg::*;
#(
   parameter int unsigned PIN_W = 6,
   parameter bit          OD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             wr_ok,
   input  gp_reg_e          wr_sel,
   input  logic [PIN_W-1:0] wbits,
   output logic [PIN_W-1:0] dir_q,
   output logic [PIN_W-1:0] data_q,
   output logic [PIN_W-1:0] odc_q
);
   logic [PIN_W-1:0] dir_r, data_r;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         dir_r  <= '0;
         data_r <= '0;
      end else if (wr_ok) begin
         unique case (wr_sel)
            REG_DIR:  dir_r  <= wbits;
            REG_DATA: data_r <= wbits;
            default:  ;
         endcase
      end
   end

   generate
      if (OD_EN) begin : g_odc
         logic [PIN_W-1:0] odc_r;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)
               odc_r <= '0;
            else if (wr_ok && wr_sel == REG_ODC)
               odc_r <= wbits;
         end
         assign odc_q = odc_r;
      end else begin : g_no_odc
         assign odc_q = '0;
      end
   endgenerate

   assign dir_q  = dir_r;
   assign data_q = data_r;
endmodule

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
   parameter int unsigned W      = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio6_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)
               stg[s] <= '0;
            else if (s == 0)
               stg[s] <= d;
            else
               stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio6_padctl.sv
module gpio6_padctl #(
   parameter int unsigned PIN_W = 6
) (
   input  logic             standby,
   input  logic [PIN_W-1:0] dir,
   input  logic [PIN_W-1:0] data,
   input  logic [PIN_W-1:0] odc,
   input  logic [PIN_W-1:0] ovr_en,
   input  logic [PIN_W-1:0] ovr_oe,
   input  logic [PIN_W-1:0] ovr_out,
   output logic [PIN_W-1:0] pad_oe,
   output logic [PIN_W-1:0] pad_out
);
   generate
      for (genvar i = 0; i < PIN_W; i++) begin : g_pin
         logic reg_oe, reg_out;
         always_comb begin
            if (odc[i]) begin
               reg_oe  = dir[i] & ~data[i];
               reg_out = 1'b0;
            end else begin
               reg_oe  = dir[i];
               reg_out = data[i];
            end
         end
         always_comb begin
            if (standby) begin
               pad_oe[i]  = 1'b0;
               pad_out[i] = 1'b0;
            end else if (ovr_en[i]) begin
               pad_oe[i]  = ovr_oe[i];
               pad_out[i] = ovr_out[i];
            end else begin
               pad_oe[i]  = reg_oe;
               pad_out[i] = reg_out;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
   import gpio6_pkg::*;
#(
   parameter int unsigned PIN_W       = 6,
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OD_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              hw_stby,
   input  logic              mrst_n,
   input  logic              sw_stby,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic [PIN_W-1:0]  pin_in,
   input  logic [PIN_W-1:0]  ovr_en,
   input  logic [PIN_W-1:0]  ovr_oe,
   input  logic [PIN_W-1:0]  ovr_out,
   output logic [PIN_W-1:0]  pad_oe,
   output logic [PIN_W-1:0]  pad_out
);
   generate
      if (PIN_W > BUS_W) begin : g_chk_w
         $error("PIN_W must not exceed BUS_W");
      end
      if (ADDR_W <= GP_SEL_W) begin : g_chk_a
         $error("ADDR_W must leave room above the register select");
      end
      if (PIN_W < BUS_W) begin : g_resv
         wire unused_resv = ^wdata[BUS_W-1:PIN_W];
      end
   endgenerate

   logic             rst_any_n, sync_rst_n;
   logic             hit, wr_ok;
   gp_reg_e          sel;
   logic [PIN_W-1:0] dir_q, data_q, odc_q, pin_s, pin_view;
   logic [PIN_W-1:0] rd_bits;

   assign rst_any_n  = por_n & ~hw_stby;
   assign sync_rst_n = por_n & mrst_n;
   assign hit        = (addr[ADDR_W-1:GP_SEL_W] == '0);
   assign sel        = gp_reg_e'(addr[GP_SEL_W-1:0]);
   assign wr_ok      = wr_en & hit & ~sw_stby;

   gpio6_regs #(.PIN_W(PIN_W), .OD_EN(OD_EN)) u_regs (
      .clk    (clk),
      .arst_n (rst_any_n),
      .wr_ok  (wr_ok),
      .wr_sel (sel),
      .wbits  (wdata[PIN_W-1:0]),
      .dir_q  (dir_q),
      .data_q (data_q),
      .odc_q  (odc_q)
   );

   gpio6_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (sync_rst_n),
      .d      (pin_in),
      .q      (pin_s)
   );

   gpio6_padctl #(.PIN_W(PIN_W)) u_pad (
      .standby (hw_stby),
      .dir     (dir_q),
      .data    (data_q),
      .odc     (odc_q),
      .ovr_en  (ovr_en),
      .ovr_oe  (ovr_oe),
      .ovr_out (ovr_out),
      .pad_oe  (pad_oe),
      .pad_out (pad_out)
   );

   assign pin_view = (dir_q & data_q) | (~dir_q & pin_s);

   always_comb begin
      unique case (sel)
         REG_DIR:  rd_bits = dir_q;
         REG_DATA: rd_bits = data_q;
         REG_PIN:  rd_bits = pin_view;
         default:  rd_bits = odc_q;
      endcase
   end

   always_comb begin
      rdata = '0;
      if (rd_en && hit)
         rdata[PIN_W-1:0] = rd_bits;
   end
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk #(
   parameter int unsigned PIN_W  = 6,
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_any_n,
   input logic              hw_stby,
   input logic              mrst_n,
   input logic              sw_stby,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [BUS_W-1:0]  rdata,
   input logic [PIN_W-1:0]  ovr_en,
   input logic [PIN_W-1:0]  ovr_oe,
   input logic [PIN_W-1:0]  pad_oe,
   input logic [PIN_W-1:0]  pad_out,
   input logic [PIN_W-1:0]  dir_q,
   input logic [PIN_W-1:0]  data_q,
   input logic [PIN_W-1:0]  odc_q
);
   logic [3*PIN_W-1:0] regs;
   assign regs = {dir_q, data_q, odc_q};

   always_comb begin
      if (hw_stby)
         assert_stby_pads_off_R1: assert (pad_oe == '0 && pad_out == '0);
   end

   assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_any_n)
      rd_en |-> rdata[BUS_W-1:PIN_W] == '0);

   assert_swstby_hold_R3: assert property (@(posedge clk) disable iff (!rst_any_n)
      (sw_stby && wr_en) |=> $stable(regs));

   assert_mrst_hold_R3: assert property (@(posedge clk) disable iff (!rst_any_n)
      (!mrst_n && !wr_en) |=> $stable(regs));

   assert_pinreg_ro_R4: assert property (@(posedge clk) disable iff (!rst_any_n)
      (wr_en && addr == ADDR_W'(2)) |=> $stable(regs));

   assert_od_no_high_R7: assert property (@(posedge clk) disable iff (!rst_any_n)
      (pad_oe & pad_out & odc_q & ~ovr_en) == '0);

   assert_override_wins_R8: assert property (@(posedge clk) disable iff (!rst_any_n)
      ((pad_oe ^ ovr_oe) & ovr_en) == '0);

   assert_rd_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_any_n)
      !rd_en |-> rdata == '0);
endmodule

bind gpio6_port gpio6_port_chk #(.PIN_W(PIN_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_any_n (rst_any_n),
   .hw_stby   (hw_stby),
   .mrst_n    (mrst_n),
   .sw_stby   (sw_stby),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .addr      (addr),
   .rdata     (rdata),
   .ovr_en    (ovr_en),
   .ovr_oe    (ovr_oe),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .dir_q     (dir_q),
   .data_q    (data_q),
   .odc_q     (odc_q)
);

// File: tb/gpio6_port_test.sv
`timescale 1ns/1ps
module gpio6_port_test;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, hw_stby = 1'b0, mrst_n = 1'b1, sw_stby = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] addr = '0, wdata = '0, rdata;
   logic [5:0] pin_in = '0, ovr_en = '0, ovr_oe = '0, ovr_out = '0;
   logic [5:0] pad_oe, pad_out;

   always #2 clk = ~clk;

   gpio6_port uut (
      .clk(clk), .por_n(por_n), .hw_stby(hw_stby), .mrst_n(mrst_n), .sw_stby(sw_stby),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .pin_in(pin_in), .ovr_en(ovr_en), .ovr_oe(ovr_oe), .ovr_out(ovr_out),
      .pad_oe(pad_oe), .pad_out(pad_out)
   );

   int    n_run = 0, n_fail = 0;
   bit    done = 0, live = 0;
   string cur_req = "R1";

   // behavioural reference state
   logic [5:0] m_dir = '0, m_dat = '0, m_odc = '0, m_s1 = '0, m_s2 = '0;

   always @(posedge clk) begin
      if (!por_n || hw_stby) begin
         m_dir = '0; m_dat = '0; m_odc = '0;
      end else if (wr_en && !sw_stby && addr < 8'd4) begin
         if (addr == 8'd0) m_dir = wdata[5:0];
         if (addr == 8'd1) m_dat = wdata[5:0];
         if (addr == 8'd3) m_odc = wdata[5:0];
      end
      if (!por_n || !mrst_n) begin
         m_s1 = '0; m_s2 = '0;
      end else begin
         m_s2 = m_s1; m_s1 = pin_in;
      end
   end

   task automatic check(string what, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1.5;
      if (live && !done) begin
         logic [5:0] ed, edt, eo, es, eoe, eout;
         logic [7:0] erd;
         ed  = (por_n && !hw_stby) ? m_dir : '0;
         edt = (por_n && !hw_stby) ? m_dat : '0;
         eo  = (por_n && !hw_stby) ? m_odc : '0;
         es  = (por_n && mrst_n) ? m_s2 : '0;
         for (int i = 0; i < 6; i++) begin
            if (hw_stby) begin eoe[i] = 0; eout[i] = 0; end
            else if (ovr_en[i]) begin eoe[i] = ovr_oe[i]; eout[i] = ovr_out[i]; end
            else if (eo[i]) begin eoe[i] = ed[i] & ~edt[i]; eout[i] = 0; end
            else begin eoe[i] = ed[i]; eout[i] = edt[i]; end
         end
         erd = '0;
         if (rd_en && addr < 8'd4) begin
            case (addr[1:0])
               2'd0: erd[5:0] = ed;
               2'd1: erd[5:0] = edt;
               2'd2: erd[5:0] = (ed & edt) | (~ed & es);
               default: erd[5:0] = eo;
            endcase
         end
         check("rdata", rdata, erd);
         check("pad_oe", {2'b00, pad_oe}, {2'b00, eoe});
         check("pad_out", {2'b00, pad_out}, {2'b00, eout});
      end
   end

   task automatic write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; rd_en = 1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 0; wdata = '0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         addr  = 8'(k % 6);
         rd_en = (k % 5) != 4;
      end
   endtask

   initial begin
      #50000;
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      cur_req = "R1";
      @(negedge clk); live = 1; rd_en = 1;
      idle(4);
      @(negedge clk); por_n = 1;
      idle(6);

      cur_req = "R6";
      write(8'd0, 8'h3F);
      write(8'd1, 8'h2A);
      idle(8);

      cur_req = "R2";
      write(8'd1, 8'hFF);
      @(negedge clk); addr = 8'd1; rd_en = 1;
      #1.5 check("R2 reserved bits", {6'd0, rdata[7:6]}, 8'd0);
      idle(6);
      write(8'd1, 8'h15);

      cur_req = "R7";
      write(8'd3, 8'h0F);
      idle(8);
      write(8'd1, 8'h2C);
      idle(6);

      cur_req = "R5";
      write(8'd0, 8'h33);
      for (int p = 0; p < 6; p++) begin
         @(negedge clk); pin_in = 6'(p * 11 + 5); addr = 8'd2; rd_en = 1;
         @(negedge clk); @(negedge clk); @(negedge clk);
      end
      write(8'd0, 8'h00);
      @(negedge clk); pin_in = 6'h2D;
      idle(5);

      cur_req = "R4";
      write(8'd2, 8'h00);
      write(8'd2, 8'h3F);
      idle(6);

      cur_req = "R9";
      write(8'd4, 8'h3F);
      write(8'd255, 8'h3F);
      write(8'd7, 8'h00);
      for (int a = 0; a < 9; a++) begin
         @(negedge clk); addr = 8'(a * 31); rd_en = a[0];
      end
      idle(6);

      cur_req = "R8";
      write(8'd0, 8'h3F);
      @(negedge clk); ovr_en = 6'h15; ovr_oe = 6'h3C; ovr_out = 6'h2B;
      idle(6);
      @(negedge clk); ovr_en = 6'h3F; ovr_oe = 6'h0F; ovr_out = 6'h33;
      idle(6);
      @(negedge clk); ovr_en = '0;

      cur_req = "R3";
      @(negedge clk); sw_stby = 1;
      write(8'd0, 8'h00);
      write(8'd1, 8'h3F);
      write(8'd3, 8'h30);
      idle(6);
      @(negedge clk); sw_stby = 0;
      @(negedge clk); mrst_n = 0; pin_in = 6'h3F;
      idle(5);
      @(negedge clk); mrst_n = 1;
      idle(6);

      cur_req = "R1";
      @(negedge clk); hw_stby = 1; ovr_en = 6'h3F; ovr_oe = 6'h3F; ovr_out = 6'h3F;
      write(8'd0, 8'h3F);
      idle(6);
      @(negedge clk); hw_stby = 0; ovr_en = '0;
      idle(6);
      write(8'd0, 8'h2F);
      @(negedge clk); por_n = 0;
      idle(4);
      @(negedge clk); por_n = 1;
      idle(6);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule